// File: doc/BRIEF.md
# Deferred Save/Restore Controller for a Register Bank

This block sits behind a two-wire serial slave front end and keeps a small bank of working configuration registers together with a nonvolatile copy of them. The front end reports start conditions, stop conditions and completed bytes. The block tells it, through one acknowledge-enable level, whether to acknowledge the byte on the bus. The block itself decodes the device address, the register index and the data bytes, and it supplies the byte to send on reads.

A master asks for a save or a restore by writing a command register. The request is only held at first, and the copy begins when the master ends the transaction with a stop condition. The copy waits out a fixed store access latency and then moves one register word per clock. While the copy runs, the block refuses its own address, so a master polls the address until it is acknowledged again. The same restore runs on its own when reset is released. The device address can take one of two values, chosen by a bit in the working registers.

Top module: `nv_cfg_keeper`

## Requirements
- R1: Reset loads the nonvolatile store with the factory pattern, where entry i holds (SEED + STEP*i) mod 256. The restore that starts when reset is released then makes every working register equal to its store entry.
- R2: After reset is released, the device address is refused for LAT+NREGS cycles. The first cycle is the one in which reset is released. After that the address is acknowledged.
- R3: The device address is the 7-bit value 0x6A (write byte 0xD4) while bit 0 of working register 0 is 0, and 0x68 (write byte 0xD0) while that bit is 1. Any other address is refused.
- R4: In a write transaction, the first byte after the address sets the register index, and each further byte is written at the index, which then increments. In a read transaction, each byte sent carries the register at the index, which then increments.
- R5: Index CMD_IDX (114) is the command register. Bit 3 requests a save and bit 0 requests a restore. A read of it returns the pending request bits at those two positions and zeros elsewhere.
- R6: A pending request does not start before a stop condition. Until then, the address is still acknowledged.
- R7: Once a request starts, the address is refused for LAT+NREGS cycles. The first cycle is the one in which the stop is taken. After that the address is acknowledged.
- R8: A save copies every working register into the store.
- R9: A restore overwrites every working register with its store entry.
- R10: The request bits clear when the copy completes.
- R11: While a copy runs, address and data bytes have no effect. A command sent then is dropped, and no further copy follows.
- R12: When bits 3 and 0 are both set, only the save runs.
- R13: Writes to indices at or above NREGS, other than CMD_IDX, are ignored, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, the power-up event |
| start_evt | input | 1 | One-cycle pulse for a start or repeated start on the bus |
| stop_evt | input | 1 | One-cycle pulse for a stop condition on the bus |
| byte_evt | input | 1 | One-cycle pulse when a byte has been received or sent |
| byte_data | input | 8 | Byte received from the master, valid with byte_evt and while the acknowledge is decided |
| ack_en | output | 1 | The front end acknowledges the current byte when this is high |
| tx_data | output | 8 | Byte to send to the master in a read transaction |

## Verification
The acknowledge level is combinational on the presented byte, so the bench samples it just after it drives the byte and before the edge that takes it. Register contents appear on tx_data one edge after the index byte. A copy starts at the edge that takes the stop. Refusal therefore covers LAT+NREGS cycles from that edge. The bench issues a start in the next cycle and begins sampling at the following falling edge, so it expects exactly LAT+NREGS-1 refused samples before the first acknowledge. The same count applies after reset, because there the start is presented in the release cycle.

// File: rtl/nv_cfg_keeper.sv
module nv_cfg_keeper #(
  parameter int NREGS = 8,
  parameter int LAT = 5,
  parameter int CMD_IDX = 114,
  parameter logic [6:0] ADDR_MAIN = 7'h6A,
  parameter logic [6:0] ADDR_ALT = 7'h68,
  parameter logic [7:0] SEED = 8'h3C,
  parameter logic [7:0] STEP = 8'd37
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       byte_evt,
  input  logic [7:0] byte_data,
  output logic       ack_en,
  output logic [7:0] tx_data
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [7:0] NR8 = 8'(NREGS);
  localparam logic [7:0] CMD8 = 8'(CMD_IDX);
  localparam logic [IW-1:0] LAST = IW'(NREGS - 1);
  localparam logic [CW-1:0] CLAST = CW'(LAT - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_COPY} st_t;
  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_PTR, P_WDAT, P_RD, P_SKIP} ph_t;

  st_t st;
  ph_t ph;
  logic op_save, cmd_save, cmd_rest;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [7:0] ptr;
  logic [7:0] regs [NREGS];
  logic [7:0] store [NREGS];

  wire [6:0] my_addr = regs[0][0] ? ADDR_ALT : ADDR_MAIN;
  wire addr_hit = byte_data[7:1] == my_addr;
  wire in_bank = ptr < NR8;
  wire idle = st == S_IDLE;

  assign ack_en = idle && ((ph == P_ADDR && addr_hit) || ph == P_PTR || ph == P_WDAT);
  assign tx_data = in_bank ? regs[ptr[IW-1:0]] :
                   (ptr == CMD8) ? {4'b0, cmd_save, 2'b0, cmd_rest} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT;
      op_save <= 1'b0;
      cnt <= '0;
      idx <= '0;
      cmd_save <= 1'b0;
      cmd_rest <= 1'b0;
      ph <= P_IDLE;
      ptr <= 8'h00;
      for (int i = 0; i < NREGS; i++) begin
        regs[i] <= 8'h00;
        store[i] <= 8'(SEED + STEP * 8'(i));
      end
    end else begin
      if (start_evt) ph <= P_ADDR;
      else if (stop_evt) ph <= P_IDLE;
      else if (byte_evt) begin
        case (ph)
          P_ADDR: ph <= (idle && addr_hit) ? (byte_data[0] ? P_RD : P_PTR) : P_SKIP;
          P_PTR: begin
            ptr <= byte_data;
            ph <= P_WDAT;
          end
          P_WDAT: begin
            if (idle) begin
              if (in_bank) regs[ptr[IW-1:0]] <= byte_data;
              else if (ptr == CMD8) begin
                cmd_save <= byte_data[3];
                cmd_rest <= byte_data[0];
              end
            end
            ptr <= ptr + 8'd1;
          end
          P_RD: ptr <= ptr + 8'd1;
          default: ;
        endcase
      end

      case (st)
        S_IDLE:
          if (stop_evt && (cmd_save || cmd_rest)) begin
            st <= S_WAIT;
            op_save <= cmd_save;
            cnt <= '0;
          end
        S_WAIT:
          if (cnt == CLAST) begin
            st <= S_COPY;
            idx <= '0;
          end else cnt <= cnt + 1'b1;
        S_COPY: begin
          if (op_save) store[idx] <= regs[idx];
          else regs[idx] <= store[idx];
          if (idx == LAST) begin
            st <= S_IDLE;
            cmd_save <= 1'b0;
            cmd_rest <= 1'b0;
          end else idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_start_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !stop_evt) |=> st == S_IDLE);
  a_r7_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !ack_en);
  a_r7_copy_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && cnt == CLAST) |=> (st == S_COPY && idx == '0));
  a_r10_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COPY && idx == LAST) |=> (!cmd_save && !cmd_rest && st == S_IDLE));
  a_r11_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |=> $stable({cmd_save, cmd_rest}));
  a_r12_save_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && stop_evt && cmd_save) |=> (st == S_WAIT && op_save));
endmodule

// File: tb/test_nv_cfg_keeper.sv
module test_nv_cfg_keeper;
  localparam int NREGS = 8;
  localparam int LAT = 5;
  localparam int BUSY = LAT + NREGS - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_evt = 1'b0, stop_evt = 1'b0, byte_evt = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic ack_en;
  logic [7:0] tx_data;
  int n_chk = 0, n_fail = 0;
  logic [7:0] wbuf [10];
  logic [7:0] ebuf [10];
  logic [7:0] dev = 8'hD4;

  always #5 clk = ~clk;

  nv_cfg_keeper i_nv_cfg_keeper (.clk(clk), .rst_n(rst_n), .start_evt(start_evt),
    .stop_evt(stop_evt), .byte_evt(byte_evt), .byte_data(byte_data),
    .ack_en(ack_en), .tx_data(tx_data));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ev_start();
    start_evt = 1'b1;
    @(negedge clk);
    start_evt = 1'b0;
  endtask

  task automatic ev_stop();
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    byte_data = b;
    #1 ack = ack_en;
    byte_evt = 1'b1;
    @(negedge clk);
    byte_evt = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    byte_data = dev;
    #1;
    while (!ack_en && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic stop_measure(output int n);
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    start_evt = 1'b1;
    byte_data = dev;
    @(negedge clk);
    start_evt = 1'b0;
    measure(n);
  endtask

  task automatic write_seq(input logic [7:0] ptr, input int n, input bit do_stop);
    logic a;
    ev_start();
    send(dev, a);
    check("R3 write address acked", a, 1);
    send(ptr, a);
    for (int i = 0; i < n; i++) send(wbuf[i], a);
    if (do_stop) ev_stop();
  endtask

  task automatic read_seq(input string req, input logic [7:0] ptr, input int n);
    logic a;
    ev_start();
    send(dev, a);
    send(ptr, a);
    ev_start();
    send(dev | 8'h01, a);
    check("R4 read address acked", a, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = tx_data;
      check(req, v, ebuf[i]);
      byte_evt = 1'b1;
      @(negedge clk);
      byte_evt = 1'b0;
    end
    ev_stop();
  endtask

  task automatic command(input logic [7:0] c, output int n);
    wbuf[0] = c;
    write_seq(8'd114, 1, 1'b0);
    stop_measure(n);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    start_evt = 1'b1;
    byte_data = dev;
    @(negedge clk);
    start_evt = 1'b0;
    measure(n);
    check("R2 power-up refusal cycles", n, BUSY);

    for (int i = 0; i < 10; i++) ebuf[i] = (i < NREGS) ? 8'(8'h3C + 8'd37 * 8'(i)) : 8'h00;
    read_seq("R1 power-up restore contents", 8'd0, 10);

    ev_start();
    send(8'hA0, a);
    check("R3 foreign address refused", a, 0);
    ev_stop();

    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h10 + 8'h29 * 8'(i));
    write_seq(8'd0, 10, 1'b1);
    for (int i = 0; i < 10; i++) ebuf[i] = (i < NREGS) ? wbuf[i] : 8'h00;
    read_seq("R4 R13 write then read", 8'd0, 10);

    wbuf[0] = 8'h08;
    write_seq(8'd114, 1, 1'b0);
    ev_start();
    send(dev, a);
    check("R6 address acked before stop", a, 1);
    send(8'd114, a);
    ev_start();
    send(dev | 8'h01, a);
    check("R5 pending bits readback", tx_data, 8'h08);
    stop_measure(n);
    check("R7 save refusal cycles", n, BUSY);
    ebuf[0] = 8'h00;
    read_seq("R10 command bits cleared", 8'd114, 1);

    for (int i = 0; i < NREGS; i++) wbuf[i] = 8'(8'h10 + 8'h29 * 8'(i)) ^ 8'hF0;
    write_seq(8'd0, NREGS, 1'b1);
    command(8'h01, n);
    check("R7 restore refusal cycles", n, BUSY);
    for (int i = 0; i < NREGS; i++) ebuf[i] = 8'(8'h10 + 8'h29 * 8'(i));
    read_seq("R8 R9 saved words restored", 8'd0, NREGS);

    for (int i = 0; i < NREGS; i++) wbuf[i] = 8'(8'h62 + 8'h16 * 8'(i)) & 8'hFE;
    write_seq(8'd0, NREGS, 1'b1);
    wbuf[0] = 8'h09;
    write_seq(8'd114, 1, 1'b0);
    stop_evt = 1'b1;
    @(negedge clk);
    stop_evt = 1'b0;
    start_evt = 1'b1;
    @(negedge clk);
    start_evt = 1'b0;
    send(dev, a);
    check("R11 address refused during copy", a, 0);
    send(8'd114, a);
    send(8'h01, a);
    ev_start();
    measure(n);
    check("R7 refusal ends", n < BUSY ? 1 : 0, 1);
    stop_measure(n);
    check("R11 no second copy after dropped command", n, 0);
    ebuf[0] = 8'h00;
    read_seq("R11 dropped command not pending", 8'd114, 1);

    for (int i = 0; i < NREGS; i++) wbuf[i] = 8'hEE;
    write_seq(8'd0, NREGS, 1'b1);
    command(8'h01, n);
    for (int i = 0; i < NREGS; i++) ebuf[i] = 8'(8'h62 + 8'h16 * 8'(i)) & 8'hFE;
    read_seq("R12 both bits ran save only", 8'd0, NREGS);

    wbuf[0] = 8'h01;
    write_seq(8'd0, 1, 1'b1);
    ev_start();
    send(8'hD4, a);
    check("R3 main address refused after select", a, 0);
    ev_start();
    send(8'hD0, a);
    check("R3 alternate address acked", a, 1);
    ev_stop();
    dev = 8'hD0;
    command(8'h01, n);
    dev = 8'hD4;
    ev_start();
    send(8'hD4, a);
    check("R3 R9 restore returns main address", a, 1);
    ev_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule